// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a 32-bit integer datapath that applies one of several clamping operations, chosen by an opcode, to two operands. It covers signed and unsigned add and subtract, signed doubling, saturation of a signed value to a runtime-selected width (both signed and unsigned ranges), and the same width saturation applied separately to the two halfwords of a word. There is also a plain add that returns the wrapped sum but still records signed overflow.

Whenever an operation has to clamp its result, a sticky overflow flag is set. The flag stays set until a dedicated clear input is asserted or reset is applied. A valid strobe starts an operation. The result appears registered one cycle later, together with a single-cycle valid pulse.

Top module: `sat_alu`

## Requirements
- R1: Reset clears the result to 0, deasserts the result valid output and clears the sticky flag.
- R2: When `in_vld` is high in cycle t, `out_vld` is high in cycle t+1 and carries that operation's result. `out_vld` is low in a cycle that follows a cycle with `in_vld` low, and the result output then holds its value.
- R3: Opcode 0 (signed add). If both operands have the same sign and the wrapped sum has the other sign, the result is 0x7FFFFFFF when `a` is non-negative and 0x80000000 when `a` is negative. Otherwise the result is the sum.
- R4: Opcode 1 (signed subtract). If the operands differ in sign and the wrapped difference's sign differs from the sign of `a`, the result clamps by the sign of `a` as in R3. Otherwise the result is a-b.
- R5: Opcode 2 (add with flag). The result is always the wrapped sum a+b, and signed overflow as defined in R3 sets the flag.
- R6: Opcode 3 (signed doubling of `a`). Values of 0x40000000 or above give 0x7FFFFFFF, values of 0xC0000000 or below (signed) give 0x80000000, and any other value gives a shifted left by 1.
- R7: Opcode 4 (unsigned add) gives 0xFFFFFFFF on carry-out. Opcode 5 (unsigned subtract) gives 0 on borrow. Otherwise each gives the wrapped result.
- R8: Opcode 6 (signed saturate of `a` to parameter n = `sh`, 0..31). If a>>>n is above 0 the result is 2^n-1, if it is below -1 the result is ~(2^n-1), and otherwise the result is a.
- R9: Opcode 7 (unsigned saturate of `a` with n = `sh`). A negative `a` gives 0, a value above 2^n-1 gives 2^n-1, and any other value gives a.
- R10: Opcodes 8 and 9 (dual-halfword signed and unsigned saturate). Each 16-bit half of `a` is sign-extended and saturated independently as in R8 and R9 with the same n. The low 16 bits of the low-half result go to bits 15:0 and the low 16 bits of the high-half result go to bits 31:16.
- R11: Any clamp sets `sat_flag` in the cycle the result appears. This includes a clamp in either half of a dual form, and overflow under opcode 2. An operation that does not clamp never clears the flag. Opcodes 10 to 15 return 0 and do not change the flag.
- R12: `clr_flag` clears the flag on the next edge. A set caused by an operation in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation strobe |
| op | input | 4 | Operation select |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| sh | input | 5 | Saturation width parameter n |
| clr_flag | input | 1 | Synchronous clear of the sticky flag |
| out_vld | output | 1 | Result valid pulse |
| res | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A wrong clamp decision shows up at `res` in the cycle right after the strobe. If the decision is lost only inside the flag path, `sat_flag` differs from the model on that same edge and stays wrong until the next clear. A flag that clears when it should not, or that loses to a simultaneous clear, also shows within one cycle. For this reason the bench compares every output against its reference on every clock, including cycles with no strobe and streams of operations that do not clamp.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   sh,
  input  logic         clr_flag,
  output logic         out_vld,
  output logic [W-1:0] res,
  output logic         sat_flag
);
  localparam int H = W / 2;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W:0] ssat(input logic [W-1:0] v, input logic [4:0] n);
    logic signed [W-1:0] top;
    logic [W-1:0] m;
    top = $signed(v) >>> n;
    m = (W'(1) << n) - W'(1);
    if (top > 0) return {1'b1, m};
    else if (top < -1) return {1'b1, ~m};
    return {1'b0, v};
  endfunction

  function automatic logic [W:0] usat(input logic [W-1:0] v, input logic [4:0] n);
    logic [W-1:0] m;
    m = (W'(1) << n) - W'(1);
    if (v[W-1]) return {1'b1, {W{1'b0}}};
    else if (v > m) return {1'b1, m};
    return {1'b0, v};
  endfunction

  logic [W-1:0] sum, dif;
  logic         cout, bout, ovf_add, ovf_sub;
  logic [W-1:0] lo_x, hi_x;
  logic [W:0]   s_full, u_full, s_lo, s_hi, u_lo, u_hi;
  logic [W-1:0] nxt;
  logic         clamp;

  assign {cout, sum} = {1'b0, a} + {1'b0, b};
  assign {bout, dif} = {1'b0, a} - {1'b0, b};
  assign ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  assign ovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
  assign lo_x = {{H{a[H-1]}}, a[H-1:0]};
  assign hi_x = {{H{a[W-1]}}, a[W-1:H]};
  assign s_full = ssat(a, sh);
  assign u_full = usat(a, sh);
  assign s_lo = ssat(lo_x, sh);
  assign s_hi = ssat(hi_x, sh);
  assign u_lo = usat(lo_x, sh);
  assign u_hi = usat(hi_x, sh);

  always_comb begin
    nxt = '0;
    clamp = 1'b0;
    case (op)
      4'd0: begin clamp = ovf_add; nxt = ovf_add ? (a[W-1] ? SMIN : SMAX) : sum; end
      4'd1: begin clamp = ovf_sub; nxt = ovf_sub ? (a[W-1] ? SMIN : SMAX) : dif; end
      4'd2: begin clamp = ovf_add; nxt = sum; end
      4'd3: begin
        if (!a[W-1] && a[W-2]) begin clamp = 1'b1; nxt = SMAX; end
        else if (a[W-1] && !a[W-2]) begin clamp = 1'b1; nxt = SMIN; end
        else if (a == {2'b11, {(W-2){1'b0}}}) begin clamp = 1'b1; nxt = SMIN; end
        else nxt = a << 1;
      end
      4'd4: begin clamp = cout; nxt = cout ? {W{1'b1}} : sum; end
      4'd5: begin clamp = bout; nxt = bout ? '0 : dif; end
      4'd6: begin clamp = s_full[W]; nxt = s_full[W-1:0]; end
      4'd7: begin clamp = u_full[W]; nxt = u_full[W-1:0]; end
      4'd8: begin clamp = s_lo[W] | s_hi[W]; nxt = {s_hi[H-1:0], s_lo[H-1:0]}; end
      4'd9: begin clamp = u_lo[W] | u_hi[W]; nxt = {u_hi[H-1:0], u_lo[H-1:0]}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      res      <= '0;
      sat_flag <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) res <= nxt;
      if (in_vld && clamp) sat_flag <= 1'b1;
      else if (clr_flag) sat_flag <= 1'b0;
    end
  end
endmodule

module sat_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [3:0]  op,
  input logic        clr_flag,
  input logic        out_vld,
  input logic [31:0] res,
  input logic        sat_flag
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld); // R2
  AST_RES_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> ($stable(res) && !out_vld)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sat_flag && !clr_flag) |=> sat_flag); // R11
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sat_flag) |-> $past(in_vld) && $past(op) <= 4'd9); // R11
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (clr_flag && !in_vld) |=> !sat_flag); // R12
endmodule

bind sat_alu sat_alu_chk u_chk (.*);

// File: tb/test_sat_alu.sv
module test_sat_alu;
  logic clk = 0, rst_n = 0, in_vld = 0, clr_flag = 0;
  logic [3:0] op = 0;
  logic [31:0] a = 0, b = 0;
  logic [4:0] sh = 0;
  logic out_vld, sat_flag;
  logic [31:0] res;
  int total = 0, bad = 0;
  bit m_vld = 0, m_flag = 0;
  longint m_res = 0;
  string m_tag = "R1";

  always #4 clk = ~clk;

  sat_alu i_sat_alu (.*);

  function automatic longint sx(input logic [31:0] v); return longint'($signed(v)); endfunction

  task automatic ref_op(input int o, input logic [31:0] x, input logic [31:0] y, input int n,
                        output logic [31:0] r, output bit c);
    longint p, lim, sa, sb;
    c = 0;
    sa = sx(x); sb = sx(y); lim = (longint'(1) << n) - 1;
    case (o)
      0, 2: begin p = sa + sb; c = (p > 32'sh7fffffff || p < -64'sd2147483648);
              r = (o == 0 && c) ? (sa < 0 ? 32'h80000000 : 32'h7fffffff) : x + y; end
      1: begin p = sa - sb; c = (p > 32'sh7fffffff || p < -64'sd2147483648);
              r = c ? (sa < 0 ? 32'h80000000 : 32'h7fffffff) : x - y; end
      3: begin if (sa >= 64'sh40000000) begin c = 1; r = 32'h7fffffff; end
               else if (sa <= -64'sh40000000) begin c = 1; r = 32'h80000000; end
               else r = x << 1; end
      4: begin p = longint'(x) + longint'(y); c = p > 64'hffffffff; r = c ? 32'hffffffff : x + y; end
      5: begin c = x < y; r = c ? 0 : x - y; end
      6: begin if (sa > lim) begin c = 1; r = lim[31:0]; end
               else if (sa < -lim - 1) begin c = 1; r = 32'(-lim - 1); end
               else r = x; end
      7: begin if (sa < 0) begin c = 1; r = 0; end
               else if (sa > lim) begin c = 1; r = lim[31:0]; end
               else r = x; end
      8, 9: begin logic [31:0] rl, rh; bit cl, chh;
               ref_op(o - 2, {{16{x[15]}}, x[15:0]}, 0, n, rl, cl);
               ref_op(o - 2, {{16{x[31]}}, x[31:16]}, 0, n, rh, chh);
               r = {rh[15:0], rl[15:0]}; c = cl | chh; end
      default: r = 0;
    endcase
  endtask

  task automatic chk(input string tag);
    total++;
    if (out_vld !== m_vld || res !== m_res[31:0] || sat_flag !== m_flag) begin
      bad++;
      $display("FAIL %s: vld=%0b res=%h flag=%0b expected vld=%0b res=%h flag=%0b",
               tag, out_vld, res, sat_flag, m_vld, m_res[31:0], m_flag);
    end
  endtask

  task automatic step(input bit v, input int o, input logic [31:0] x, input logic [31:0] y,
                      input int n, input bit clr, input string tag);
    logic [31:0] r; bit c;
    in_vld = v; op = 4'(o); a = x; b = y; sh = 5'(n); clr_flag = clr;
    ref_op(o, x, y, n, r, c);
    @(posedge clk); #1;
    m_vld = v;
    if (v) m_res = {32'b0, r};
    if (v && c) m_flag = 1; else if (clr) m_flag = 0;
    in_vld = 0; clr_flag = 0;
    chk(tag);
  endtask

  initial begin
    fork
      begin #1600000; bad++; total++; $display("FAIL watchdog"); end
    join_none
    repeat (3) @(posedge clk); #1;
    chk("R1");
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 32'h7fffffff, 1, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, "R12");
    step(1, 0, 32'h80000000, 32'hffffffff, 0, 0, "R3");
    step(1, 0, 5, 7, 0, 1, "R12");
    step(1, 1, 32'h80000000, 1, 0, 0, "R4");
    step(1, 1, 32'h7fffffff, 32'hffffffff, 0, 1, "R12");
    step(1, 1, 10, 3, 0, 1, "R4");
    step(1, 2, 32'h7fffffff, 1, 0, 0, "R5");
    step(1, 2, 3, 4, 0, 1, "R12");
    step(1, 3, 32'h40000000, 0, 0, 0, "R6");
    step(1, 3, 32'hc0000000, 0, 0, 1, "R6");
    step(1, 3, 32'hc0000001, 0, 0, 1, "R6");
    step(1, 3, 32'h3fffffff, 0, 0, 0, "R6");
    step(1, 4, 32'hffffffff, 1, 0, 1, "R7");
    step(1, 5, 1, 2, 0, 1, "R7");
    step(1, 5, 9, 2, 0, 1, "R7");
    step(1, 6, 200, 0, 7, 1, "R8");
    step(1, 6, 32'hffffff00, 0, 7, 1, "R8");
    step(1, 6, 32'hffffff80, 0, 7, 1, "R8");
    step(1, 7, 32'hffffffff, 0, 4, 1, "R9");
    step(1, 7, 16, 0, 4, 1, "R9");
    step(1, 7, 15, 0, 4, 1, "R9");
    step(1, 8, 32'h0005_7000, 0, 8, 1, "R10");
    step(1, 8, 32'h8000_0005, 0, 8, 1, "R10");
    step(1, 9, 32'h0010_ffff, 0, 8, 1, "R10");
    step(1, 9, 32'h0010_0020, 0, 8, 1, "R10");
    step(1, 12, 32'hffffffff, 5, 3, 0, "R11");
    step(1, 0, 1, 1, 0, 0, "R11");
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 11),
           ($urandom_range(0, 1) != 0) ? $urandom : {$urandom_range(0, 3), 30'($urandom)},
           $urandom, $urandom_range(0, 31), $urandom_range(0, 5) == 0, "R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule